// File: doc/BRIEF.md
# Framing Error Snapshot Counter

This block counts frame alignment errors reported by an E1 receive framer and, on demand, moves the running count into a holding register that software can read at leisure. The live counter only advances while the framer reports that it holds basic frame synchronization, so errors seen while hunting for alignment are not counted. The counter stops at its maximum value instead of wrapping.

A transfer (snapshot) copies the live count into the holding register and restarts the live count. A transfer has three sources:
- a software write to the count register address;
- a one-cycle global update strobe shared by every channel;
- a one-second tick, when the auto-update bit is set.

Each transfer raises a done flag. A transfer that replaces a snapshot software has not yet read raises an overrun flag. Reading the status register clears both flags. An interrupt output follows the done flag when the interrupt enable is set.

Top module: `fes_snap_top`

## Requirements
- R1: The live count increments on a cycle with `err_i`=1 only when `sync_i`=1; with `sync_i`=0 the error is not counted.
- R2: The live count saturates at 2^CNT_W-1 (127 by default) and never wraps.
- R3: A write to address 2 (count) transfers the live count into the holding register. In the same cycle the live count restarts at 0, or at 1 if a counted error arrives in that cycle.
- R4: Control register at address 0 holds bit 0 = auto-update enable and bit 1 = interrupt enable (read/write). With auto-update set, `tick_1s_i` causes a transfer; with it clear, the tick is ignored.
- R5: `glob_upd_i` causes a transfer regardless of the control bits.
- R6: Reading address 2 returns the holding register in bits CNT_W-1..0, with all higher bits 0. Address 3 reads 0.
- R7: Status register at address 1, bit 0 (done) is set by every transfer and cleared by a status read. If a transfer happens in the same cycle as the read, the flag stays set.
- R8: Status bit 1 (overrun) is set by a transfer when the holding register has not been read since the previous transfer. A count read in the same cycle as the transfer counts as a read. The bit is cleared by a status read.
- R9: `irq_o` is 1 exactly when done=1 and interrupt enable=1, and it stays high until a status read or until the enable is cleared.
- R10: After reset the control and status registers read 0 and `irq_o` is 0. The holding register is undefined until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | One framing error event this cycle |
| sync_i | input | 1 | Framer is in basic frame synchronization |
| tick_1s_i | input | 1 | One-cycle pulse each second |
| glob_upd_i | input | 1 | One-cycle global transfer strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default CNT_W of 7. At this width a directed burst of 130 counted errors drives the live count past 127 and shows that it holds there. The same width leaves bit 7 of the count read free, so the bench can check that it reads zero. Long random runs with sparse ticks and global strobes cover several coincidences: a transfer in the same cycle as an error, in the same cycle as a status read, and in the same cycle as a count read.

// File: rtl/fes_snap_pkg.sv
package fes_snap_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_STAT  = 2'd1,
    A_COUNT = 2'd2,
    A_RSVD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fes_live_cnt.sv
module fes_live_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (xfer_i)               cnt_o <= inc_i ? ONE : '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/fes_hold.sv
module fes_hold #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o
);
  // no reset: contents are undefined until the first transfer
  always_ff @(posedge clk_i) begin
    if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/fes_flags.sv
module fes_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_i,
  input  logic cnt_rd_i,
  input  logic stat_rd_i,
  output logic done_o,
  output logic ovr_o
);
  logic unread_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      ovr_o    <= 1'b0;
      unread_q <= 1'b0;
    end else if (xfer_i) begin
      done_o   <= 1'b1;
      ovr_o    <= (unread_q && !cnt_rd_i) || (ovr_o && !stat_rd_i);
      unread_q <= 1'b1;
    end else begin
      if (stat_rd_i) begin
        done_o <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (cnt_rd_i) unread_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fes_snap_top.sv
module fes_snap_top
  import fes_snap_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic              sync_i,
  input  logic              tick_1s_i,
  input  logic              glob_upd_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             auto_en, irq_en;
  logic             cnt_wr, cnt_rd, stat_rd, ctrl_we;
  logic             xfer, inc;
  logic             done, ovr;
  logic [CNT_W-1:0] live_cnt, hold_cnt;
  logic             unused_wdata;

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);
  assign cnt_wr  = reg_we_i && (reg_addr_i == A_COUNT);
  assign cnt_rd  = reg_re_i && (reg_addr_i == A_COUNT);
  assign stat_rd = reg_re_i && (reg_addr_i == A_STAT);
  assign inc     = err_i && sync_i;
  assign xfer    = cnt_wr || glob_upd_i || (tick_1s_i && auto_en);
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_en <= 1'b0;
      irq_en  <= 1'b0;
    end else if (ctrl_we) begin
      auto_en <= reg_wdata_i[0];
      irq_en  <= reg_wdata_i[1];
    end
  end

  fes_live_cnt #(.CNT_W(CNT_W)) i_live (
    .clk_i (clk_i), .rst_ni(rst_ni), .inc_i(inc), .xfer_i(xfer), .cnt_o(live_cnt)
  );

  fes_hold #(.CNT_W(CNT_W)) i_hold (
    .clk_i(clk_i), .load_i(xfer), .d_i(live_cnt), .q_o(hold_cnt)
  );

  fes_flags i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .xfer_i(xfer), .cnt_rd_i(cnt_rd),
    .stat_rd_i(stat_rd), .done_o(done), .ovr_o(ovr)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {{(DATA_W-2){1'b0}}, irq_en, auto_en};
      A_STAT:  reg_rdata_o = {{(DATA_W-2){1'b0}}, ovr, done};
      A_COUNT: reg_rdata_o = {{PAD_W{1'b0}}, hold_cnt};
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = done && irq_en;
endmodule

// File: rtl/fes_snap_chk.sv
module fes_snap_chk
  import fes_snap_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              tick_1s_i,
  input logic              glob_upd_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic              xfer,
  input logic              auto_en,
  input logic              done,
  input logic [CNT_W-1:0]  live_cnt
);
  localparam logic [CNT_W-1:0] MAX = '1;
  logic stat_rd, ctrl_we, cnt_wr;
  assign stat_rd = reg_re_i && reg_addr_i == A_STAT;
  assign ctrl_we = reg_we_i && reg_addr_i == A_CTRL;
  assign cnt_wr  = reg_we_i && reg_addr_i == A_COUNT;

  a_r1_no_count_unsynced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !xfer) |=> $stable(live_cnt));

  a_r2_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt == MAX && !xfer) |=> live_cnt == MAX);

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> live_cnt <= 1);

  a_r4_tick_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_1s_i && !auto_en && !glob_upd_i && !cnt_wr && !done) |=> !done);

  a_r5_global_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_upd_i |=> done);

  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_COUNT) |-> reg_rdata_o[DATA_W-1:CNT_W] == '0);

  a_r7_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !xfer) |=> !done);

  a_r9_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_rd && !ctrl_we) |=> irq_o);
endmodule

bind fes_snap_top fes_snap_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .tick_1s_i(tick_1s_i),
  .glob_upd_i(glob_upd_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
  .xfer(xfer), .auto_en(auto_en), .done(done), .live_cnt(live_cnt)
);

// File: tb/test_fes_snap_top.sv
module test_fes_snap_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 7;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic err_i = 0, sync_i = 0, tick_1s_i = 0, glob_upd_i = 0;
  logic reg_we_i = 0, reg_re_i = 0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o;

  int checks = 0, failures = 0;
  bit done_run = 0;

  int m_live = 0, m_hold = 0;
  bit m_done = 0, m_ovr = 0, m_unread = 0, m_auto = 0, m_ien = 0, m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fes_snap_top #(.CNT_W(CNT_W)) i_fes_snap_top (
    .clk_i(clk), .rst_ni(rst_ni), .err_i(err_i), .sync_i(sync_i),
    .tick_1s_i(tick_1s_i), .glob_upd_i(glob_upd_i), .reg_we_i(reg_we_i),
    .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {6'b0, m_ien, m_auto};
      2'd1: return {6'b0, m_ovr, m_done};
      2'd2: return 8'(m_hold);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [1:0] a,
                      input logic [7:0] wd, input bit e, input bit s,
                      input bit t, input bit g, input string tag);
    bit xf, inc, crd, srd;
    @(negedge clk);
    reg_we_i = we; reg_re_i = re; reg_addr_i = a; reg_wdata_i = wd;
    err_i = e; sync_i = s; tick_1s_i = t; glob_upd_i = g;
    #1;
    if (re && !(a == 2'd2 && !m_valid)) chk(tag, reg_rdata_o, exp_read(a));
    chk("R9 irq", irq_o, m_done && m_ien);
    @(posedge clk);
    xf  = (we && a == 2'd2) || g || (t && m_auto);
    inc = e && s;
    crd = re && a == 2'd2;
    srd = re && a == 2'd1;
    if (xf) begin
      m_ovr    = (m_unread && !crd) || (m_ovr && !srd);
      m_done   = 1;
      m_unread = 1;
      m_hold   = m_live;
      m_live   = inc ? 1 : 0;
      m_valid  = 1;
    end else begin
      if (inc && m_live < MAXC) m_live++;
      if (srd) begin m_done = 0; m_ovr = 0; end
      if (crd) m_unread = 0;
    end
    if (we && a == 2'd0) begin m_auto = wd[0]; m_ien = wd[1]; end
  endtask

  task automatic idle(input bit e, input bit s);
    step(0, 0, 2'd0, 8'h00, e, s, 0, 0, "idle");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 1, a, 8'h00, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R10 reset state
    rd(2'd0, "R10 ctrl");
    rd(2'd1, "R10 stat");
    rd(2'd3, "R6 reserved");
    // R3: five counted errors, transfer with error in same cycle
    repeat (5) idle(1, 1);
    step(1, 0, 2'd2, 8'h00, 1, 1, 0, 0, "R3 write");
    rd(2'd2, "R3 R6 count");
    // R1: unsynced errors ignored; R5 global strobe transfers carried 1
    repeat (4) idle(1, 0);
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 1, "R5 glob");
    rd(2'd2, "R1 R5 count");
    // R2 saturation
    repeat (MAXC + 3) idle(1, 1);
    step(1, 0, 2'd2, 8'h00, 0, 0, 0, 0, "R2 write");
    rd(2'd2, "R2 count");
    rd(2'd1, "R7 R8 stat");
    rd(2'd1, "R7 cleared");
    // R4 tick ignored when auto off, honoured when on
    step(0, 0, 2'd0, 8'h00, 0, 0, 1, 0, "R4 tick off");
    rd(2'd1, "R4 no xfer");
    step(1, 0, 2'd0, 8'h01, 0, 0, 0, 0, "R4 ctrl");
    rd(2'd0, "R4 ctrl rb");
    step(0, 0, 2'd0, 8'h00, 0, 0, 1, 0, "R4 tick on");
    rd(2'd1, "R4 xfer done");
    // R8 overrun: two transfers without a count read
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 1, "R8 glob1");
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 1, "R8 glob2");
    rd(2'd1, "R8 ovr set");
    // R8 count read in transfer cycle is a read
    rd(2'd2, "R8 clr unread");
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 1, "R8 g3");
    step(0, 1, 2'd2, 8'h00, 0, 0, 0, 1, "R8 rd+xfer");
    rd(2'd1, "R8 no ovr");
    // R7 transfer during status read keeps done
    step(0, 1, 2'd1, 8'h00, 0, 0, 0, 1, "R7 rd+xfer");
    rd(2'd1, "R7 done kept");
    // R9 interrupt
    step(1, 0, 2'd0, 8'h02, 0, 0, 0, 0, "R9 ien");
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 1, "R9 glob");
    idle(0, 0); idle(0, 0);
    rd(2'd1, "R9 stat");
    idle(0, 0);
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 16;
      bit e = $urandom % 2;
      bit s = ($urandom % 4) != 0;
      bit t = ($urandom % 8) == 0;
      bit g = ($urandom % 32) == 0;
      case (op)
        0: step(1, 0, 2'd0, 8'($urandom), e, s, t, g, "R4 R9 rnd ctrl");
        1: step(1, 0, 2'd2, 8'h00, e, s, t, g, "R3 rnd wr");
        2, 3: step(0, 1, 2'd1, 8'h00, e, s, t, g, "R7 R8 rnd stat");
        4: step(0, 1, 2'd2, 8'h00, e, s, t, g, "R1 R2 R3 rnd count");
        5: step(0, 1, 2'd0, 8'h00, e, s, t, g, "R4 rnd ctrl rd");
        default: step(0, 0, 2'd3, 8'h00, e, s, t, g, "rnd idle");
      endcase
    end
    if (!done_run) begin
      done_run = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_run) begin
      done_run = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule